// File: doc/BRIEF.md
# Two-Bank DRAM Row/Column Address Multiplexer

This block sits between a 16-bit CPU bus and two independent DRAM banks. For each access request it takes the word address from the bus, decides which bank the access belongs to, and runs a fixed strobe sequence. It first presents the row half of the address together with that bank's row strobe. It then switches the shared 10-bit address lines to the column half, and finally asserts that bank's column strobe. Each bank can be set to hold 128 KiB, 512 KiB or 2 MiB. The column bits are taken from a position in the CPU address that depends on the size setting of the bank being accessed.

The decoding is kept simple on purpose. An access to the second bank is not rebased by the size of the first bank, and address bits above the bank's own range are not cleared. When bank 1 is set larger than bank 0, a bank-1 access therefore lands at a predictable aliased offset inside bank 1. This is the expected result and the bench checks it.

The CPU bus carries no bit 0, because every access is a full word. The size settings are captured when an access starts and are held for the rest of that access.

Top module: `dram_bank_mux`

## Requirements
- R1: In the first cycle of an access, while the row strobe is asserted and the column strobe is not, the multiplexed address equals CPU address bits 10 down to 1, with bit 1 on line 0. This holds for every size setting.
- R2: In the column phase the multiplexed address, from line 0 up to line 9, is CPU bits 18..9 for size code 00 (128 KiB), bits 19..10 for code 01 (512 KiB) and bits 20..11 for code 10 (2 MiB). The code used is the one of the bank being accessed.
- R3: An address below the bank-0 capacity (0x20000, 0x80000 or 0x200000 for codes 00, 01 and 10) selects bank 0, which is strobe bit 0. Any other address selects bank 1, which is strobe bit 1.
- R4: On a bank-1 access the column bits come from the raw address, with no subtraction of the bank-0 capacity and no masking of high bits. With codes 00/00, address 0x20000 gives column 0x100. With codes 00/01 it gives column 0x080.
- R5: A request seen in the idle state at a clock edge gives row plus row strobe in the next cycle and the column address in the cycle after that. The column strobe follows one cycle later and is held for exactly two cycles, while the row strobe stays asserted.
- R6: In the cycle after the column strobe hold, both strobes are released and the acknowledge is high for exactly one cycle. Then the block returns to idle.
- R7: The strobes of the bank that is not selected stay low for the whole access. All strobes and the acknowledge are low after reset and while idle.
- R8: Size code 11 behaves exactly like code 10 (2 MiB), both for bank selection and for column selection.
- R9: The size inputs are sampled only when an access starts. Changing them during an access has no effect on its bank choice or column address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | ADDR_W-1 (bits ADDR_W-1..1) | CPU word address, no bit 0 |
| req_i | input | 1 | Access request, sampled in idle |
| bank0_size_i | input | 2 | Bank 0 size code |
| bank1_size_i | input | 2 | Bank 1 size code |
| dram_addr_o | output | MUX_W | Multiplexed row/column address |
| ras_o | output | 2 | Row strobe per bank, active high |
| cas_o | output | 2 | Column strobe per bank, active high |
| ack_o | output | 1 | One-cycle completion pulse |

## Verification
The row-address property assumes that the bus address is valid in the same cycle the request is first seen in idle. The bench drives address, sizes and request together on the falling edge to meet this. The release properties assume that a request is not withdrawn and reissued inside an access, so the bench holds the request high until it sees the acknowledge and drops it in that same cycle. The size inputs are the only ones changed in the middle of an access, and only in the scenario that tests their capture.

// File: rtl/dram_mux_pkg.sv
`timescale 1ns/1ps
package dram_mux_pkg;

   typedef enum logic [1:0] {
      SZ_128K  = 2'b00,
      SZ_512K  = 2'b01,
      SZ_2M    = 2'b10,
      SZ_2M_X  = 2'b11
   } bank_size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_CAS,
      ST_DONE
   } seq_state_e;

   localparam int unsigned NUM_SIZES = 3;

   // Folds the spare code onto the largest size.
   function automatic logic [1:0] size_rank(input logic [1:0] code);
      return (code == SZ_2M_X) ? 2'(SZ_2M) : code;
   endfunction

endpackage

// File: rtl/dram_col_pick.sv
`timescale 1ns/1ps
module dram_col_pick
   import dram_mux_pkg::*;
#(
   parameter int MUX_W = 10
)(
   input  logic [MUX_W+1:0] win_i,
   input  logic [1:0]       size_i,
   output logic [MUX_W-1:0] col_o
);

   logic [MUX_W-1:0] cand [NUM_SIZES];

   if (MUX_W < 2) begin : g_bad_width
      $error("dram_col_pick: MUX_W must be at least 2");
   end

   // Each larger size shifts the column window up by one bit.
   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_cand
      assign cand[k] = win_i[k +: MUX_W];
   end

   always_comb begin
      unique case (size_rank(size_i))
         2'b00:   col_o = cand[0];
         2'b01:   col_o = cand[1];
         default: col_o = cand[2];
      endcase
   end

endmodule

// File: rtl/dram_bank_decode.sv
`timescale 1ns/1ps
module dram_bank_decode
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int MUX_W  = 10
)(
   input  logic [ADDR_W-1:1] addr_i,
   input  logic [1:0]        size0_i,
   input  logic [1:0]        size1_i,
   output logic              bank_sel_o,
   output logic [MUX_W-1:0]  row_o,
   output logic [MUX_W-1:0]  col_o
);

   // log2 of the smallest bank capacity in bytes
   localparam int BASE_LG = 2*MUX_W - 3;

   if (ADDR_W < 2*MUX_W + 2) begin : g_bad_addr
      $error("dram_bank_decode: ADDR_W too small for the 2 MiB size");
   end

   logic [NUM_SIZES-1:0] above;
   logic [1:0]           sel_size;

   // above[k]: address at or beyond the capacity of size rank k
   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_thr
      assign above[k] = |addr_i[ADDR_W-1:BASE_LG+2*k];
   end

   always_comb begin
      unique case (size_rank(size0_i))
         2'b00:   bank_sel_o = above[0];
         2'b01:   bank_sel_o = above[1];
         default: bank_sel_o = above[2];
      endcase
   end

   assign row_o    = addr_i[MUX_W:1];
   assign sel_size = bank_sel_o ? size1_i : size0_i;

   // Raw address window, no rebasing and no masking for bank 1
   dram_col_pick #(.MUX_W(MUX_W)) u_col (
      .win_i  (addr_i[2*MUX_W:MUX_W-1]),
      .size_i (sel_size),
      .col_o  (col_o)
   );

endmodule

// File: rtl/dram_access_seq.sv
`timescale 1ns/1ps
module dram_access_seq
   import dram_mux_pkg::*;
#(
   parameter int CAS_HOLD = 2
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   output logic start_o,
   output logic col_phase_o,
   output logic ras_on_o,
   output logic cas_on_o,
   output logic ack_o
);

   localparam int CW = $clog2(CAS_HOLD + 1);

   if (CAS_HOLD < 1) begin : g_bad_hold
      $error("dram_access_seq: CAS_HOLD must be at least 1");
   end

   seq_state_e    state_q, state_d;
   logic [CW-1:0] hold_q;

   assign start_o = (state_q == ST_IDLE) && req_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_i) state_d = ST_ROW;
         ST_ROW:  state_d = ST_COL;
         ST_COL:  state_d = ST_CAS;
         ST_CAS:  if (hold_q == CW'(CAS_HOLD - 1)) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_CAS) hold_q <= hold_q + 1'b1;
         else                   hold_q <= '0;
      end
   end

   assign col_phase_o = (state_q == ST_COL) || (state_q == ST_CAS);
   assign ras_on_o    = (state_q == ST_ROW) || col_phase_o;
   assign cas_on_o    = (state_q == ST_CAS);
   assign ack_o       = (state_q == ST_DONE);

   // R5: the column strobe only starts after a column-address cycle
   p_cas_after_col_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cas_on_o) |-> $past(col_phase_o) && !$past(cas_on_o));

   // R6: acknowledge lasts one cycle
   p_ack_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |=> !ack_o);

endmodule

// File: rtl/dram_bank_mux.sv
`timescale 1ns/1ps
module dram_bank_mux
   import dram_mux_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int MUX_W    = 10,
   parameter int CAS_HOLD = 2
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:1] cpu_addr_i,
   input  logic              req_i,
   input  logic [1:0]        bank0_size_i,
   input  logic [1:0]        bank1_size_i,
   output logic [MUX_W-1:0]  dram_addr_o,
   output logic [1:0]        ras_o,
   output logic [1:0]        cas_o,
   output logic              ack_o
);

   localparam int BANKS = 2;

   logic [ADDR_W-1:1] addr_q;
   logic [1:0]        size0_q, size1_q;
   logic              start, col_phase, ras_on, cas_on, bank_sel;
   logic [MUX_W-1:0]  row, col;

   // Address and sizes captured once per access (R9)
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         size0_q <= SZ_128K;
         size1_q <= SZ_128K;
      end else if (start) begin
         addr_q  <= cpu_addr_i;
         size0_q <= bank0_size_i;
         size1_q <= bank1_size_i;
      end
   end

   dram_bank_decode #(.ADDR_W(ADDR_W), .MUX_W(MUX_W)) u_dec (
      .addr_i     (addr_q),
      .size0_i    (size0_q),
      .size1_i    (size1_q),
      .bank_sel_o (bank_sel),
      .row_o      (row),
      .col_o      (col)
   );

   dram_access_seq #(.CAS_HOLD(CAS_HOLD)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req_i),
      .start_o     (start),
      .col_phase_o (col_phase),
      .ras_on_o    (ras_on),
      .cas_on_o    (cas_on),
      .ack_o       (ack_o)
   );

   assign dram_addr_o = col_phase ? col : row;

   for (genvar b = 0; b < BANKS; b++) begin : g_strobe
      assign ras_o[b] = ras_on && (bank_sel == 1'(b));
      assign cas_o[b] = cas_on && (bank_sel == 1'(b));
   end

   // R1: row lines carry the word address sampled at the start
   p_row_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(|ras_o) |-> dram_addr_o == $past(cpu_addr_i[MUX_W:1]));

   // R5: address lines do not move while a column strobe is active
   p_col_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|cas_o) |-> $stable(dram_addr_o) && (ras_o == cas_o));

   // R6: release of all strobes coincides with the acknowledge
   p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o |-> (ras_o == '0) && (cas_o == '0) && $past(|cas_o));

   // R7: only one bank strobed, and it does not change mid-access
   p_one_bank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ras_o) && $onehot0(cas_o));

   p_bank_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|ras_o) && $past(|ras_o)) |-> ras_o == $past(ras_o));

endmodule

// File: tb/dram_bank_mux_test.sv
`timescale 1ns/1ps
module dram_bank_mux_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:1] addr = '0;
   logic        req = 1'b0;
   logic [1:0]  sz0 = 2'b00, sz1 = 2'b00;
   logic [9:0]  mux;
   logic [1:0]  ras, cas;
   logic        ack;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   dram_bank_mux uut (
      .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .req_i(req),
      .bank0_size_i(sz0), .bank1_size_i(sz1),
      .dram_addr_o(mux), .ras_o(ras), .cas_o(cas), .ack_o(ack)
   );

   function automatic int rank(input logic [1:0] c);
      return (c == 2'b11) ? 2 : int'(c);
   endfunction

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [14:0] act, input logic [14:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   // Packed observation {ras,cas,ack,mux}
   function automatic logic [14:0] obs();
      return {ras, cas, ack, mux};
   endfunction

   task automatic run_access(input logic [23:0] a, input logic [1:0] s0,
                             input logic [1:0] s1, input bit alter,
                             input logic [1:0] n0, input logic [1:0] n1,
                             input string rq);
      bit          bank;
      logic [1:0]  m;
      logic [9:0]  row, col;
      logic [14:0] e;
      bank = (a >= (24'd1 << (17 + 2*rank(s0))));
      m    = bank ? 2'b10 : 2'b01;
      row  = a[10:1];
      col  = 10'((a >> (9 + rank(bank ? s1 : s0))) & 24'h3FF);
      @(negedge clk);
      addr = a[23:1]; sz0 = s0; sz1 = s1; req = 1'b1;
      @(negedge clk);
      e = {m, 2'b00, 1'b0, row};
      chk(obs() == e, rq, "row phase", obs(), e);
      if (alter) begin sz0 = n0; sz1 = n1; end
      @(negedge clk);
      e = {m, 2'b00, 1'b0, col};
      chk(obs() == e, rq, "column phase", obs(), e);
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         e = {m, m, 1'b0, col};
         chk(obs() == e, rq, "cas hold", obs(), e);
      end
      @(negedge clk);
      chk({ras, cas, ack} == 5'b00001, rq, "release+ack",
          15'({ras, cas, ack}), 15'h1);
      req = 1'b0;
      @(negedge clk);
      chk({ras, cas, ack} == 5'b0, rq, "back to idle",
          15'({ras, cas, ack}), 15'h0);
   endtask

   task automatic t_reset();
      chk({ras, cas, ack} == 5'b0, "R7", "reset outputs",
          15'({ras, cas, ack}), 15'h0);
   endtask

   task automatic t_patterns(); // R1 R2 R5 R6
      run_access(24'h0ABCDE, 2'b10, 2'b10, 1'b0, 2'b00, 2'b00, "R2");
      run_access(24'h01F3FE, 2'b01, 2'b00, 1'b0, 2'b00, 2'b00, "R1");
      run_access(24'h01555A, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, "R5");
      run_access(24'h1AAAAA, 2'b10, 2'b01, 1'b0, 2'b00, 2'b00, "R6");
   endtask

   task automatic t_threshold(); // R3 boundaries for each code
      run_access(24'h01FFFE, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, "R3");
      run_access(24'h020000, 2'b00, 2'b10, 1'b0, 2'b00, 2'b00, "R3");
      run_access(24'h07FFFE, 2'b01, 2'b01, 1'b0, 2'b00, 2'b00, "R3");
      run_access(24'h080000, 2'b01, 2'b00, 1'b0, 2'b00, 2'b00, "R3");
      run_access(24'h1FFFFE, 2'b10, 2'b00, 1'b0, 2'b00, 2'b00, "R3");
      run_access(24'h200000, 2'b10, 2'b00, 1'b0, 2'b00, 2'b00, "R3");
   endtask

   task automatic t_alias(); // R4 raw bank-1 columns (0x100, 0x080, 0x100)
      run_access(24'h020000, 2'b00, 2'b00, 1'b0, 2'b00, 2'b00, "R4");
      run_access(24'h020000, 2'b00, 2'b01, 1'b0, 2'b00, 2'b00, "R4");
      run_access(24'h080000, 2'b01, 2'b10, 1'b0, 2'b00, 2'b00, "R4");
      run_access(24'hF3C000, 2'b00, 2'b01, 1'b0, 2'b00, 2'b00, "R4");
   endtask

   task automatic t_code11(); // R8
      run_access(24'h1FFFFE, 2'b11, 2'b00, 1'b0, 2'b00, 2'b00, "R8");
      run_access(24'h200000, 2'b11, 2'b11, 1'b0, 2'b00, 2'b00, "R8");
      run_access(24'h020000, 2'b00, 2'b11, 1'b0, 2'b00, 2'b00, "R8");
   endtask

   task automatic t_size_capture(); // R9 sizes change after the row phase
      run_access(24'h020000, 2'b00, 2'b00, 1'b1, 2'b10, 2'b10, "R9");
      run_access(24'h0C0000, 2'b10, 2'b00, 1'b1, 2'b00, 2'b01, "R9");
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_patterns();
      t_threshold();
      t_alias();
      t_code11();
      t_size_capture();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule